// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU inputs of a five-stage, single-issue pipeline, whether the operand read from the register file is still current. If it is not, the block takes a newer value from a result that is still in flight further down the pipeline. It compares the two source register numbers of the instruction in execute with the destination register numbers of the instructions in the memory and writeback stages. From those compares it produces one 2-bit select code per operand.

Each producer stage can forward only if it is writing a register and that register is not register zero. When both producers match the same source, the memory-stage result wins, because it comes from the more recent instruction. The two operands are decided separately.

For convenience the top also contains the two operand multiplexers. A pipeline can therefore take either the select codes or the chosen operands directly. The selection logic holds no state and has no clock.

Top module: `operand_bypass_ctrl`

## Requirements
- R1: With no matching producer, an operand's select code is 00 and the operand output equals its register-file input.
- R2: When the memory-stage write flag is set, its destination is nonzero, and it equals operand A's source (first source) or operand B's source (second source), that operand's select code is 10.
- R3: When the writeback-stage write flag is set, its destination is nonzero and equals the operand's source, and the memory stage does not forward to that operand, the select code is 01.
- R4: A stage whose write flag is clear never forwards, whatever its destination number is.
- R5: A destination of register zero never forwards, even with the write flag set; a source of register zero always gets select 00.
- R6: When both stages would forward to the same operand, the select code is 10, so the newest value is used. This includes the case where all three instructions in flight name one register.
- R7: The two operands are decided independently: one producer can feed A, B or both, and A and B can take different stages at the same time.
- R8: The operand output follows the select code: 00 gives the register-file value, 10 gives the memory-stage result and 01 gives the writeback-stage result.
- R9: The select code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W (5) | First source register number of the instruction in execute |
| ex_src_b | input | REG_W (5) | Second source register number of the instruction in execute |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W (5) | Memory-stage destination register number |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | REG_W (5) | Writeback-stage destination register number |
| rf_a | input | DATA_W (32) | Operand A as read from the register file |
| rf_b | input | DATA_W (32) | Operand B as read from the register file |
| mem_result | input | DATA_W (32) | Result held in the memory-stage pipeline register |
| wb_result | input | DATA_W (32) | Result held in the writeback-stage pipeline register |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | DATA_W (32) | Chosen operand A |
| opnd_b | output | DATA_W (32) | Chosen operand B |

## Verification
The bench builds the block with its defaults: 5-bit register numbers, 32-bit data, and register-zero suppression enabled. The 5-bit width puts both extremes of the register space in reach, register 0 and register 31. With suppression enabled, the cases where a producer writes register zero with its write flag set can be checked. The 32-bit data width lets each of the three data sources carry a distinct pattern, so every select choice shows up as a different operand value.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

   // Operand source selection; the code values are seen by the consuming mux.
   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_WB      = 2'b01,
      SEL_MEM     = 2'b10
   } bypass_sel_e;

   localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/bypass_match.sv
// Decides whether one producer stage may supply one source register.
module bypass_match #(
   parameter int unsigned REG_W     = 5,
   parameter bit          SKIP_ZERO = 1'b1
) (
   input  logic             wr_en,
   input  logic [REG_W-1:0] dst,
   input  logic [REG_W-1:0] src,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   if (REG_W < 1) begin : g_bad_width
      $error("bypass_match: REG_W must be at least 1");
   end

   logic same_reg;
   assign same_reg = (dst == src);

   if (SKIP_ZERO) begin : g_zero_hardwired
      assign hit = wr_en && same_reg && (dst != ZERO_REG);
   end else begin : g_zero_plain
      assign hit = wr_en && same_reg;
   end

   always_comb begin
      if (!wr_en) begin
         AST_NO_WRITE_NO_HIT : assert (!hit) else $error("hit without write flag"); // R4
      end
   end
endmodule

// File: rtl/bypass_select.sv
// Resolves priority between the memory-stage and writeback-stage matches.
module bypass_select
   import bypass_pkg::*;
(
   input  logic        mem_hit,
   input  logic        wb_hit,
   output bypass_sel_e sel
);
   always_comb begin
      if (mem_hit) begin
         sel = SEL_MEM;
      end else if (wb_hit) begin
         sel = SEL_WB;
      end else begin
         sel = SEL_REGFILE;
      end
   end

   always_comb begin
      AST_NO_CODE_11 : assert (sel != bypass_sel_e'(2'b11)) else $error("illegal select"); // R9
      if (mem_hit && wb_hit) begin
         AST_NEWEST_WINS : assert (sel == SEL_MEM) else $error("older result chosen"); // R6
      end
      if (!mem_hit && !wb_hit) begin
         AST_IDLE_REGFILE : assert (sel == SEL_REGFILE) else $error("forward with no hit"); // R1
      end
   end
endmodule

// File: rtl/bypass_opmux.sv
// Operand multiplexer driven by a select code.
module bypass_opmux
   import bypass_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  bypass_sel_e       sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] opnd
);
   if (DATA_W < 1) begin : g_bad_width
      $error("bypass_opmux: DATA_W must be at least 1");
   end

   always_comb begin
      case (sel)
         SEL_MEM: opnd = mem_val;
         SEL_WB:  opnd = wb_val;
         default: opnd = rf_val;
      endcase
   end

   always_comb begin
      if (sel == SEL_MEM) begin
         AST_MUX_MEM : assert (opnd == mem_val) else $error("mux mem path"); // R8
      end
      if (sel == SEL_WB) begin
         AST_MUX_WB : assert (opnd == wb_val) else $error("mux wb path"); // R8
      end
   end
endmodule

// File: rtl/operand_bypass_ctrl.sv
module operand_bypass_ctrl
   import bypass_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned DATA_W    = 32,
   parameter bit          SKIP_ZERO = 1'b1
) (
   input  logic [REG_W-1:0]  ex_src_a,
   input  logic [REG_W-1:0]  ex_src_b,
   input  logic              mem_wr_en,
   input  logic [REG_W-1:0]  mem_dst,
   input  logic              wb_wr_en,
   input  logic [REG_W-1:0]  wb_dst,
   input  logic [DATA_W-1:0] rf_a,
   input  logic [DATA_W-1:0] rf_b,
   input  logic [DATA_W-1:0] mem_result,
   input  logic [DATA_W-1:0] wb_result,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);
   localparam int unsigned NUM_OPND = 2;
   localparam logic [REG_W-1:0] ZERO_REG = '0;

   if (REG_W < 1 || DATA_W < 1) begin : g_bad_cfg
      $error("operand_bypass_ctrl: widths must be positive");
   end

   logic [REG_W-1:0]  src_v  [NUM_OPND];
   logic [DATA_W-1:0] rf_v   [NUM_OPND];
   logic [DATA_W-1:0] opnd_v [NUM_OPND];
   bypass_sel_e       sel_v  [NUM_OPND];
   logic              mem_hit_v [NUM_OPND];
   logic              wb_hit_v  [NUM_OPND];

   assign src_v[0] = ex_src_a;
   assign src_v[1] = ex_src_b;
   assign rf_v[0]  = rf_a;
   assign rf_v[1]  = rf_b;

   for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
      bypass_match #(.REG_W(REG_W), .SKIP_ZERO(SKIP_ZERO)) u_mem_match (
         .wr_en (mem_wr_en),
         .dst   (mem_dst),
         .src   (src_v[g]),
         .hit   (mem_hit_v[g])
      );

      bypass_match #(.REG_W(REG_W), .SKIP_ZERO(SKIP_ZERO)) u_wb_match (
         .wr_en (wb_wr_en),
         .dst   (wb_dst),
         .src   (src_v[g]),
         .hit   (wb_hit_v[g])
      );

      bypass_select u_sel (
         .mem_hit (mem_hit_v[g]),
         .wb_hit  (wb_hit_v[g]),
         .sel     (sel_v[g])
      );

      bypass_opmux #(.DATA_W(DATA_W)) u_mux (
         .sel     (sel_v[g]),
         .rf_val  (rf_v[g]),
         .mem_val (mem_result),
         .wb_val  (wb_result),
         .opnd    (opnd_v[g])
      );
   end

   assign sel_a  = sel_v[0];
   assign sel_b  = sel_v[1];
   assign opnd_a = opnd_v[0];
   assign opnd_b = opnd_v[1];

   always_comb begin
      if (SKIP_ZERO && ex_src_a == ZERO_REG) begin
         AST_ZERO_SRC_A : assert (sel_a == 2'b00) else $error("r0 forwarded to A"); // R5
      end
      if (SKIP_ZERO && ex_src_b == ZERO_REG) begin
         AST_ZERO_SRC_B : assert (sel_b == 2'b00) else $error("r0 forwarded to B"); // R5
      end
      if (mem_wr_en && mem_dst != ZERO_REG && mem_dst == ex_src_a) begin
         AST_MEM_TO_A : assert (sel_a == 2'b10 && opnd_a == mem_result)
            else $error("A missed memory result"); // R2
      end
      if (ex_src_a == ex_src_b) begin
         AST_SAME_SRC_SAME_SEL : assert (sel_a == sel_b) else $error("A/B disagree"); // R7
      end
   end
endmodule

// File: tb/operand_bypass_ctrl_tb.sv
module operand_bypass_ctrl_tb_top;
   localparam int REG_W  = 5;
   localparam int DATA_W = 32;
   localparam int NVEC   = 12;
   localparam int WATCHDOG_CYCLES = 2000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic [REG_W-1:0]  ex_src_a, ex_src_b, mem_dst, wb_dst;
   logic              mem_wr_en, wb_wr_en;
   logic [DATA_W-1:0] rf_a, rf_b, mem_result, wb_result;
   logic [1:0]        sel_a, sel_b;
   logic [DATA_W-1:0] opnd_a, opnd_b;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   operand_bypass_ctrl #(.REG_W(REG_W), .DATA_W(DATA_W), .SKIP_ZERO(1'b1)) dut_i (
      .ex_src_a, .ex_src_b, .mem_wr_en, .mem_dst, .wb_wr_en, .wb_dst,
      .rf_a, .rf_b, .mem_result, .wb_result,
      .sel_a, .sel_b, .opnd_a, .opnd_b
   );

   // {src_a, src_b, mem_we, mem_dst, wb_we, wb_dst, exp_a, exp_b}
   localparam logic [25:0] VECS [NVEC] = '{
      {5'd1,  5'd2,  1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00}, // R1 idle
      {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R2 mem->A
      {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b01}, // R3 wb->B
      {5'd5,  5'd5,  1'b1, 5'd5,  1'b0, 5'd0,  2'b10, 2'b10}, // R7 one producer both
      {5'd6,  5'd7,  1'b1, 5'd6,  1'b1, 5'd7,  2'b10, 2'b01}, // R7 different stages
      {5'd8,  5'd8,  1'b1, 5'd8,  1'b1, 5'd8,  2'b10, 2'b10}, // R6 all same reg
      {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R5 r0 with writes
      {5'd9,  5'd10, 1'b0, 5'd9,  1'b1, 5'd9,  2'b01, 2'b00}, // R4 mem not writing
      {5'd11, 5'd12, 1'b1, 5'd12, 1'b1, 5'd12, 2'b00, 2'b10}, // R6 on B
      {5'd31, 5'd30, 1'b1, 5'd30, 1'b1, 5'd31, 2'b01, 2'b10}, // R7 crossed
      {5'd13, 5'd14, 1'b0, 5'd13, 1'b0, 5'd14, 2'b00, 2'b00}, // R4 both flags clear
      {5'd0,  5'd15, 1'b1, 5'd0,  1'b1, 5'd15, 2'b00, 2'b01}  // R5 mem r0 ignored
   };

   task automatic check(input string req, input string what,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] sa, input logic [4:0] sb, input logic mw,
                        input logic [4:0] md, input logic ww, input logic [4:0] wd);
      @(negedge clk);
      ex_src_a = sa; ex_src_b = sb;
      mem_wr_en = mw; mem_dst = md; wb_wr_en = ww; wb_dst = wd;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG_CYCLES) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG_CYCLES);
         finish_run();
      end
   end

   initial begin
      rf_a = 32'hAAAA_0001; rf_b = 32'hBBBB_0002;
      mem_result = 32'h3E3E_0003; wb_result = 32'h5B5B_0004;
      drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
      check("R1", "reset sel_a", 32'(sel_a), 32'd0);
      check("R1", "reset opnd_b", opnd_b, rf_b);
      repeat (2) @(posedge clk);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         logic [25:0] v;
         v = VECS[i];
         drive(v[25:21], v[20:16], v[15], v[14:10], v[9], v[8:4]);
         check("R2/R3/R4/R5/R6/R7", $sformatf("vec%0d sel_a", i), 32'(sel_a), 32'(v[3:2]));
         check("R2/R3/R4/R5/R6/R7", $sformatf("vec%0d sel_b", i), 32'(sel_b), 32'(v[1:0]));
         check("R9", $sformatf("vec%0d no code 11", i), 32'(sel_a == 2'b11 || sel_b == 2'b11), 32'd0);
      end

      // R8: data follows select for each code
      drive(5'd6, 5'd7, 1'b1, 5'd6, 1'b1, 5'd7);
      check("R8", "opnd_a from mem", opnd_a, mem_result);
      check("R8", "opnd_b from wb", opnd_b, wb_result);
      drive(5'd2, 5'd3, 1'b1, 5'd9, 1'b1, 5'd10);
      check("R1", "opnd_a from rf", opnd_a, rf_a);
      check("R8", "opnd_b from rf", opnd_b, rf_b);

      // R6: all three in flight write register 7 -> newest value on both operands
      drive(5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 5'd7);
      check("R6", "triple write opnd_a", opnd_a, mem_result);
      check("R6", "triple write opnd_b", opnd_b, mem_result);

      // R5: register zero destination with write flags set, source zero
      drive(5'd0, 5'd1, 1'b1, 5'd0, 1'b1, 5'd0);
      check("R5", "r0 dst opnd_a", opnd_a, rf_a);
      check("R5", "r0 dst sel_b", 32'(sel_b), 32'd0);

      // R4: write flag clear but matching destinations
      drive(5'd20, 5'd21, 1'b0, 5'd20, 1'b0, 5'd21);
      check("R4", "no write opnd_a", opnd_a, rf_a);
      check("R4", "no write opnd_b", opnd_b, rf_b);

      // R3: writeback blocked by memory on A only, B still gets writeback
      drive(5'd17, 5'd18, 1'b1, 5'd17, 1'b1, 5'd18);
      check("R3", "wb to B alongside mem to A", opnd_b, wb_result);

      finish_run();
   end
endmodule